// File: doc/BRIEF.md
# Binary to 3-of-6 Array Address Encoder

This block turns an 11-bit binary word address into the select lines of a memory array built from eight substacks of small bit-sliced storage packages. Each package picks a word line from a six-wire code and a bit line from a second six-wire code. Both codes have a constant weight of three, so exactly three wires of each group are high for any address. Two further address bits pick one of four substack pairs with a one-hot select. The top address bit picks the left or the right half of the stack, and together with the pair select it enables exactly one substack.

The encoded address goes into a register that has two strobes. The capture strobe loads a new address. The hold strobe keeps the present one. When neither strobe is high, the register clears and every line goes low. Every substack that is not enabled sees all twelve of its address lines low, so only the selected substack gets a live code. The encoder does not generate the strobes. An upstream timing sequencer drives them. Because the interface is a strobed register and not a data stream, there is no back-pressure: a capture always takes effect.

Top module: `addr3of6_encoder`

## Requirements
- R1: `x_code` is a 3-of-6 code of the nibble n = addr[3:0]. Bits [5:4] are n[3:2]. Bits [3:0] depend on g = n[3:2] and i = n[1:0]: for g=0 they are 4'b1111 with bit i cleared; for g=3 only bit i is set; for g=1 or g=2 bits i and (i+1) mod 4 are set. Value 0 gives 6'b001110, and the 16 nibbles give 16 distinct codes.
- R2: `x_code[5]` equals address bit addr[3] and `x_code[4]` equals addr[2] for every captured address.
- R3: `y_code` is produced from addr[9:6] with the same table as R1.
- R4: `pair_sel` is one-hot: the value v = addr[5:4] sets bit 3-v (00 selects pair 3, 01 pair 2, 10 pair 1, 11 pair 0). Pair p joins substacks p and p+4.
- R5: `half_sel` equals addr[10] (1 = right half, substacks 4 to 7). Substack s is enabled only when `pair_sel[s mod 4]` is high and `half_sel` equals s/4.
- R6: For the enabled substack s, `sub_x[6s+5:6s]` equals `x_code` and `sub_y[6s+5:6s]` equals `y_code`. All lines of every other substack are 0.
- R7: A high `capture_en` at a rising clock edge loads the encoded address, and the outputs show it after that edge.
- R8: With `hold_en` high and `capture_en` low, every output keeps its value whatever `addr` does. When both strobes are high, the capture wins.
- R9: With both strobes low at an edge, every output is 0 after that edge. Reset (`rst_n` low) also forces every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 11 | Binary word address |
| capture_en | input | 1 | Load the encoded address at this edge |
| hold_en | input | 1 | Keep the registered address when not capturing |
| x_code | output | 6 | Registered word-line code (3-of-6) |
| y_code | output | 6 | Registered bit-line code (3-of-6) |
| pair_sel | output | 4 | One-hot substack pair select |
| half_sel | output | 1 | Stack half select, 1 = right |
| sub_x | output | 48 | Gated word-line codes, 6 per substack |
| sub_y | output | 48 | Gated bit-line codes, 6 per substack |

## Verification
The sweep runs all 16 nibble values at the same time as a complementary Y nibble and a varying pair and half. It exposes table errors, errors in the directly wired bits, and codes that collide, because every observed X code is checked for distinctness once the sweep ends. A walk through all eight pair and half combinations separates errors in the pair decode from errors in the substack gating. Hold cycles change the address on purpose, so a register that keeps loading shows up. Cycles with both strobes high test that capture wins, and cycles with neither strobe test the clear.

// File: rtl/addr3of6_pkg.sv
package addr3of6_pkg;
  localparam int NIB_W    = 4;
  localparam int CODE_W   = 6;
  localparam int PAIR_W   = 2;
  localparam int N_PAIRS  = 1 << PAIR_W;
  localparam int N_HALVES = 2;
  localparam int N_SUB    = N_PAIRS * N_HALVES;
  localparam int ADDR_W   = 2 * NIB_W + PAIR_W + 1;
  localparam int SUB_BUS  = N_SUB * CODE_W;

  typedef logic [CODE_W-1:0] code6_t;
endpackage

// File: rtl/addr3of6_code.sv
module addr3of6_code
  import addr3of6_pkg::*;
(
  input  logic [NIB_W-1:0] nib,
  output code6_t           code
);
  logic [NIB_W-1:0]   one_bit;
  logic [2*NIB_W-1:0] rot_pair;
  logic [NIB_W-1:0]   low;

  always_comb begin
    one_bit  = 4'b0001 << nib[1:0];
    rot_pair = {4'b0011, 4'b0011} << nib[1:0];
    case (nib[3:2])
      2'b00:   low = ~one_bit;
      2'b11:   low = one_bit;
      default: low = rot_pair[2*NIB_W-1:NIB_W];
    endcase
    code = {nib[3], nib[2], low};
  end
endmodule

// File: rtl/addr3of6_pairsel.sv
module addr3of6_pairsel
  import addr3of6_pkg::*;
(
  input  logic [PAIR_W-1:0]  sel,
  output logic [N_PAIRS-1:0] pair_oh
);
  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
    assign pair_oh[p] = (sel == PAIR_W'(N_PAIRS - 1 - p));
  end
endmodule

// File: rtl/addr3of6_gate.sv
module addr3of6_gate
  import addr3of6_pkg::*;
(
  input  logic [N_PAIRS-1:0] pair_q,
  input  logic               half_q,
  input  code6_t             x_q,
  input  code6_t             y_q,
  output logic [SUB_BUS-1:0] sub_x,
  output logic [SUB_BUS-1:0] sub_y
);
  for (genvar h = 0; h < N_HALVES; h++) begin : g_half
    for (genvar p = 0; p < N_PAIRS; p++) begin : g_sub
      localparam int S = h * N_PAIRS + p;
      logic en;
      assign en = pair_q[p] & (half_q == h[0]);
      assign sub_x[S*CODE_W +: CODE_W] = en ? x_q : '0;
      assign sub_y[S*CODE_W +: CODE_W] = en ? y_q : '0;
    end
  end
endmodule

// File: rtl/addr3of6_encoder.sv
module addr3of6_encoder
  import addr3of6_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                capture_en,
  input  logic                hold_en,
  output logic [CODE_W-1:0]   x_code,
  output logic [CODE_W-1:0]   y_code,
  output logic [N_PAIRS-1:0]  pair_sel,
  output logic                half_sel,
  output logic [SUB_BUS-1:0]  sub_x,
  output logic [SUB_BUS-1:0]  sub_y
);
  localparam int PAIR_LSB = NIB_W;
  localparam int Y_LSB    = NIB_W + PAIR_W;
  localparam int HALF_BIT = ADDR_W - 1;

  code6_t x_d, y_d, x_q, y_q;
  logic [N_PAIRS-1:0] pair_d, pair_q;
  logic half_q;

  addr3of6_code u_xcode (.nib(addr[NIB_W-1:0]),         .code(x_d));
  addr3of6_code u_ycode (.nib(addr[Y_LSB +: NIB_W]),    .code(y_d));
  addr3of6_pairsel u_pair (.sel(addr[PAIR_LSB +: PAIR_W]), .pair_oh(pair_d));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0; y_q <= '0; pair_q <= '0; half_q <= 1'b0;
    end else if (capture_en) begin
      x_q <= x_d; y_q <= y_d; pair_q <= pair_d; half_q <= addr[HALF_BIT];
    end else if (!hold_en) begin
      x_q <= '0; y_q <= '0; pair_q <= '0; half_q <= 1'b0;
    end
  end

  addr3of6_gate u_gate (
    .pair_q(pair_q), .half_q(half_q), .x_q(x_q), .y_q(y_q),
    .sub_x(sub_x), .sub_y(sub_y)
  );

  assign x_code   = x_q;
  assign y_code   = y_q;
  assign pair_sel = pair_q;
  assign half_sel = half_q;

  a_r1_weight3: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |=> ($countones(x_code) == 3 && $countones(y_code) == 3));

  a_r2_direct_bits: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |=> (x_code[5:4] == $past(addr[3:2])));

  a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pair_sel));

  a_r7_pair_load: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |=> (pair_sel == (4'b1000 >> $past(addr[PAIR_LSB +: PAIR_W]))));

  a_r6_single_sub: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(sub_x) <= 3 && $countones(sub_y) <= 3));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_en && !capture_en) |=> ($stable(x_code) && $stable(y_code)
                                  && $stable(pair_sel) && $stable(half_sel)));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_en && !capture_en) |=> (pair_sel == '0 && x_code == '0
                                   && sub_x == '0 && sub_y == '0));
endmodule

// File: tb/addr3of6_encoder_test.sv
module addr3of6_encoder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] addr = '0;
  logic        capture_en = 1'b0;
  logic        hold_en = 1'b0;
  logic [5:0]  x_code, y_code;
  logic [3:0]  pair_sel;
  logic        half_sel;
  logic [47:0] sub_x, sub_y;

  addr3of6_encoder uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .capture_en(capture_en),
    .hold_en(hold_en), .x_code(x_code), .y_code(y_code),
    .pair_sel(pair_sel), .half_sel(half_sel), .sub_x(sub_x), .sub_y(sub_y)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [5:0]  x, y;
    logic [3:0]  pair;
    logic        half;
    logic [47:0] sx, sy;
    logic        rec;
    logic [3:0]  nib;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [5:0] seen [16];

  logic [5:0]  m_x = '0, m_y = '0;
  logic [3:0]  m_pair = '0;
  logic        m_half = 1'b0;

  function automatic logic [5:0] ref_code(input logic [3:0] n);
    logic [3:0] lo;
    int i;
    i = int'(n[1:0]);
    lo = '0;
    if (n[3:2] == 2'b00) begin
      lo = 4'b1111; lo[i] = 1'b0;
    end else if (n[3:2] == 2'b11) begin
      lo[i] = 1'b1;
    end else begin
      lo[i] = 1'b1; lo[(i+1) % 4] = 1'b1;
    end
    return {n[3], n[2], lo};
  endfunction

  // kind: 0 capture, 1 hold, 2 idle, 3 capture with hold
  task automatic op(input int kind, input logic [10:0] a, input bit rec, input string tag);
    item_t it;
    @(negedge clk);
    addr       = a;
    capture_en = (kind == 0 || kind == 3);
    hold_en    = (kind == 1 || kind == 3);
    if (capture_en) begin
      m_x = ref_code(a[3:0]);
      m_y = ref_code(a[9:6]);
      m_pair = '0; m_pair[3 - int'(a[5:4])] = 1'b1;
      m_half = a[10];
    end else if (!hold_en) begin
      m_x = '0; m_y = '0; m_pair = '0; m_half = 1'b0;
    end
    it.x = m_x; it.y = m_y; it.pair = m_pair; it.half = m_half;
    it.sx = '0; it.sy = '0;
    for (int s = 0; s < 8; s++) begin
      if (m_pair[s % 4] && (m_half == (s / 4))) begin
        it.sx[s*6 +: 6] = m_x;
        it.sy[s*6 +: 6] = m_y;
      end
    end
    it.rec = rec; it.nib = a[3:0]; it.tag = tag;
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (x_code !== e.x || y_code !== e.y || pair_sel !== e.pair ||
            half_sel !== e.half || sub_x !== e.sx || sub_y !== e.sy) begin
          errors++;
          $display("FAIL %s: x=%b y=%b pair=%b half=%b subx=%h suby=%h expected x=%b y=%b pair=%b half=%b subx=%h suby=%h",
                   e.tag, x_code, y_code, pair_sel, half_sel, sub_x, sub_y,
                   e.x, e.y, e.pair, e.half, e.sx, e.sy);
        end
        if (e.rec) seen[e.nib] = x_code;
      end
    end
  end

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    int dup;
    repeat (3) @(posedge clk);
    #2;
    // R9: reset state
    checks++;
    if (x_code !== '0 || y_code !== '0 || pair_sel !== '0 || half_sel !== 1'b0 ||
        sub_x !== '0 || sub_y !== '0) begin
      errors++;
      $display("FAIL R9 reset: x=%b pair=%b subx=%h expected all zero", x_code, pair_sel, sub_x);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R3 R6: sweep of every nibble
    for (int n = 0; n < 16; n++) begin
      logic [3:0] nn, yy;
      logic [1:0] pp;
      nn = 4'(n); yy = 4'(15 - n); pp = nn[1:0];
      op(0, {nn[0] ^ nn[3], yy, pp, nn}, 1'b1, "R1/R2/R3/R6 sweep");
    end
    // R4 R5: all pair and half combinations
    for (int k = 0; k < 8; k++) begin
      logic [2:0] kk;
      kk = 3'(k);
      op(0, {kk[2], 4'(k + 3), kk[1:0], 4'(k * 5)}, 1'b0, "R4/R5 pair-half walk");
    end
    // R8: hold keeps the value while addr changes
    op(0, 11'b10110100101, 1'b0, "R7 capture");
    op(1, 11'b01001011010, 1'b0, "R8 hold");
    op(1, 11'b11111111111, 1'b0, "R8 hold");
    op(3, 11'b00011110000, 1'b0, "R8 capture wins");
    op(1, 11'b00000000000, 1'b0, "R8 hold after capture");
    // R9: clear with neither strobe
    op(2, 11'b11111111111, 1'b0, "R9 idle clear");
    op(2, 11'b00000000000, 1'b0, "R9 idle stays clear");
    op(1, 11'b10101010101, 1'b0, "R8 hold of cleared");
    op(0, 11'b00000000000, 1'b0, "R7 capture zero address");
    op(0, 11'b11111111111, 1'b0, "R7 back-to-back capture");
    op(2, 11'b00000000000, 1'b0, "R9 final clear");

    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);

    // R1: the 16 observed X codes are distinct
    dup = 0;
    for (int a = 0; a < 16; a++)
      for (int b = a + 1; b < 16; b++)
        if (seen[a] === seen[b]) dup++;
    checks++;
    if (dup != 0) begin
      errors++;
      $display("FAIL R1 distinct: %0d duplicate code pairs, expected 0", dup);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule